// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial frame. It takes characters from an upstream read port, such as a FIFO or a holding register, through a one-cycle pop strobe. It keeps one character in its own holding register and moves it into a shifter when the line is free. Each frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Every bit lasts 16 pulses of a 16x baud enable that the surrounding design supplies. Two status outputs report when the holding register is empty and when the whole transmitter is empty. An interrupt controller can use them.

The sequencer has six states. IDLE holds the line high. START sends the start bit. DATA sends the data bits. PARITY sends the parity bit. STOP1 and STOP2 send the stop bits. The transitions are:
- IDLE→START when the holding register is full and freeze is low.
- START→DATA at the end of a bit.
- DATA→DATA at the end of each data bit except the last.
- DATA→PARITY after the last data bit when parity is on.
- DATA→STOP1 after the last data bit when parity is off.
- PARITY→STOP1 at the end of the parity bit.
- STOP1→STOP2 when two stop bits are set.
- STOP1→IDLE when one stop bit is set.
- STOP2→IDLE at the end of the second stop bit.
- Any state→IDLE while freeze is high.

The word length, parity and stop settings are captured when a frame starts. A break input forces the line low. A freeze input returns the sequencer to IDLE.

Top module: `uart_tx_frame`

## Requirements
- R1: After reset `txd` is 1, `thr_empty` and `tx_empty` are 1, and `src_rd` is 0 while `src_valid` is 0.
- R2: A frame begins with a start bit of 0 and sends data least significant bit first. Every bit of the frame lasts exactly 16 `baud_tick` pulses.
- R3: `cfg_len` selects the data-bit count: 0→5, 1→6, 2→7, 3→8. Bits of `src_data` above the selected count are not sent and do not affect parity.
- R4: With `cfg_par_en`=1 a parity bit follows the data. With `cfg_par_odd`=1 the data bits plus the parity bit hold an odd number of ones. With `cfg_par_odd`=0 they hold an even number. With `cfg_par_en`=0 no parity bit is sent.
- R5: `cfg_stop2`=0 sends one stop bit of 1 and `cfg_stop2`=1 sends two. When nothing else is queued, `tx_empty` goes to 1 within 3 clock cycles after the last tick of the final stop bit.
- R6: The word-length, parity and stop settings are sampled when a frame starts. Changing them during a frame has no effect on that frame.
- R7: `src_rd` pulses for one cycle when the holding register is empty, `src_valid` is 1 and `freeze` is 0, and `src_data` is captured in that cycle. `thr_empty` is 0 from the next cycle until the character moves to the shifter, so a second character waits while the first is sent. Back-to-back frames follow with no lost character.
- R8: `tx_empty` is 1 only when the holding register is empty and the sequencer is in IDLE. It is 0 during every bit of a frame.
- R9: While `cfg_break` is 1, `txd` is 0 from the next cycle on, whatever the state. When the break is released from idle, `txd` returns to 1 on the next cycle.
- R10: While `freeze` is 1 the sequencer is in IDLE from the next cycle on and `txd` is 1 (unless a break is also requested). No character is popped while `freeze` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | 16x baud enable, one-cycle pulses |
| freeze | input | 1 | Stop the sequencer and hold it in IDLE |
| cfg_len | input | 2 | Data-bit count code (0→5 … 3→8) |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one |
| cfg_break | input | 1 | Force the serial line low |
| src_valid | input | 1 | Upstream has a character available |
| src_data | input | 8 | Upstream character |
| src_rd | output | 1 | Pop strobe to the upstream port |
| txd | output | 1 | Serial output, idles high |
| thr_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
A wrong sequencer state or a wrong bit index shows up on `txd` as a wrong level at the middle of some bit. That is at most 16 ticks after the error, so a frame decoder sampling the middle of each bit catches it within the frame. A bit timer that runs fast or slow shifts every later mid-bit sample. It also moves the rise of `tx_empty` away from the tick count the frame should take. That timing check catches a wrong stop-bit count by the end of the frame. A holding-register flag that is stuck or wrong shows at `src_rd` and `thr_empty` within one cycle: as an extra pop, a lost character or a missing pop.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } tx_cfg_t;

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [TW-1:0] LAST = TW'(OVS - 1);

    logic [TW-1:0] cnt_q;

    assign bit_end = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              take,
    output logic [DATA_W-1:0] dout,
    output logic              full
);
    logic [DATA_W-1:0] data_q;
    logic              full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else if (load) begin
            data_q <= din;
            full_q <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign dout = data_q;
    assign full = full_q;
endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              odd,
    output logic              par
);
    logic [DATA_W-1:0] used;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign used[i] = data[i] & (IDX_W'(i) <= last_idx);
    end

    assign par = odd ? ~(^used) : (^used);
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              freeze,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic              cfg_break,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_rd,
    output logic              txd,
    output logic              thr_empty,
    output logic              tx_empty
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LEN_BASE = IDX_W'(DATA_W - 4);

    tx_state_e         state_q, state_d;
    tx_cfg_t           cfg_in, cfg_q;
    logic [DATA_W-1:0] shift_q;
    logic [IDX_W-1:0]  bitcnt_q;
    logic [IDX_W-1:0]  last_idx_in, last_idx_q;
    logic              par_q, par_bit;
    logic              hold_full, start_frame, bit_end, line_bit, txd_q;
    logic [DATA_W-1:0] hold_data;

    assign cfg_in      = '{len: cfg_len, par_en: cfg_par_en,
                           par_odd: cfg_par_odd, stop2: cfg_stop2};
    assign last_idx_in = LEN_BASE + IDX_W'(cfg_in.len);
    assign last_idx_q  = LEN_BASE + IDX_W'(cfg_q.len);

    assign src_rd      = !hold_full && src_valid && !freeze;
    assign start_frame = (state_q == ST_IDLE) && hold_full && !freeze;

    tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (src_rd),
        .din  (src_data),
        .take (start_frame),
        .dout (hold_data),
        .full (hold_full)
    );

    tx_bit_timer #(.OVS(OVS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_frame || freeze),
        .run    (state_q != ST_IDLE),
        .tick   (baud_tick),
        .bit_end(bit_end)
    );

    tx_parity_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_par (
        .data    (hold_data),
        .last_idx(last_idx_in),
        .odd     (cfg_in.par_odd),
        .par     (par_bit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_frame) state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA:   if (bit_end && bitcnt_q == last_idx_q)
                           state_d = cfg_q.par_en ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_end) state_d = ST_STOP1;
            ST_STOP1:  if (bit_end) state_d = cfg_q.stop2 ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (bit_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= ST_IDLE;
        else if (freeze) state_q <= ST_IDLE;
        else             state_q <= state_d;
    end

    // Frame datapath: shifter, bit index, captured settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q  <= '0;
            bitcnt_q <= '0;
            cfg_q    <= '0;
            par_q    <= 1'b0;
        end else if (start_frame) begin
            shift_q  <= hold_data;
            bitcnt_q <= '0;
            cfg_q    <= cfg_in;
            par_q    <= par_bit;
        end else if (state_q == ST_DATA && bit_end) begin
            shift_q  <= shift_q >> 1;
            bitcnt_q <= bitcnt_q + 1'b1;
        end
    end

    // Line level selected by state
    always_comb begin
        unique case (state_q)
            ST_IDLE:   line_bit = 1'b1;
            ST_START:  line_bit = 1'b0;
            ST_DATA:   line_bit = shift_q[0];
            ST_PARITY: line_bit = par_q;
            ST_STOP1:  line_bit = 1'b1;
            ST_STOP2:  line_bit = 1'b1;
            default:   line_bit = 1'b1;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         txd_q <= 1'b1;
        else if (cfg_break) txd_q <= 1'b0;
        else if (freeze)    txd_q <= 1'b1;
        else                txd_q <= line_bit;
    end

    assign txd       = txd_q;
    assign thr_empty = !hold_full;
    assign tx_empty  = !hold_full && (state_q == ST_IDLE);
endmodule

// File: rtl/uart_tx_frame_chk.sv
module uart_tx_frame_chk (
    input logic clk,
    input logic rst_n,
    input logic freeze,
    input logic cfg_break,
    input logic src_valid,
    input logic src_rd,
    input logic txd,
    input logic thr_empty,
    input logic tx_empty
);
    a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_break |=> !txd);

    a_r10_freeze_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !cfg_break) |=> txd);

    a_r10_no_pop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> !src_rd);

    a_r7_pop_fills: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd |=> !thr_empty);

    a_r7_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd |-> src_valid);

    a_r8_empty_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> thr_empty);

    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !cfg_break) |=> txd);
endmodule

bind uart_tx_frame uart_tx_frame_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (freeze),
    .cfg_break(cfg_break),
    .src_valid(src_valid),
    .src_rd   (src_rd),
    .txd      (txd),
    .thr_empty(thr_empty),
    .tx_empty (tx_empty)
);

// File: tb/uart_tx_frame_test.sv
`timescale 1ns/1ps
module uart_tx_frame_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       freeze = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_break = 1'b0;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_rd, txd, thr_empty, tx_empty;

    typedef struct {
        logic [7:0] d;
        logic [1:0] len;
        logic       pe;
        logic       po;
        logic       s2;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    uart_tx_frame uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .freeze(freeze),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_break(cfg_break), .src_valid(src_valid),
        .src_data(src_data), .src_rd(src_rd), .txd(txd),
        .thr_empty(thr_empty), .tx_empty(tx_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // 16x enable: one pulse every third cycle
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            baud_tick = (ph == 2);
            ph = (ph + 1) % 3;
        end
    end

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(negedge clk);
            if (baud_tick) c++;
        end
    endtask

    // Handshake one character into the block
    task automatic hand(input logic [7:0] d);
        src_data  = d;
        src_valid = 1'b1;
        #1;
        while (!src_rd) @(negedge clk);
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        exp_t e;
        e.d = d; e.len = cfg_len; e.pe = cfg_par_en; e.po = cfg_par_odd; e.s2 = cfg_stop2;
        exp_q.push_back(e);
        hand(d);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || !tx_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: decode frames at mid-bit and compare with the scoreboard
    initial begin
        forever begin
            exp_t e;
            int   nb;
            logic [7:0] m;
            logic pbit;
            wait (exp_q.size() > 0);
            e = exp_q[0];
            while (txd !== 1'b0) @(negedge clk);
            nb = 5 + int'(e.len);
            m  = e.d & 8'((1 << nb) - 1);
            wait_ticks(8);
            chk(txd === 1'b0, "R2 start bit", txd, 0);
            chk(tx_empty === 1'b0, "R8 busy during frame", tx_empty, 0);
            for (int i = 0; i < nb; i++) begin
                wait_ticks(16);
                chk(txd === e.d[i], "R3 data bit lsb first", txd, e.d[i]);
            end
            if (e.pe) begin
                pbit = e.po ? ~(^m) : (^m);
                wait_ticks(16);
                chk(txd === pbit, "R4 parity bit", txd, pbit);
            end
            wait_ticks(16);
            chk(txd === 1'b1, "R5 first stop bit", txd, 1);
            if (e.s2) begin
                wait_ticks(16);
                chk(txd === 1'b1, "R5 second stop bit", txd, 1);
            end
            chk(tx_empty === 1'b0, "R8 busy in last stop", tx_empty, 0);
            void'(exp_q.pop_front());
            wait_ticks(8);
            repeat (3) @(negedge clk);
            if (exp_q.size() == 0 && !src_valid && thr_empty)
                chk(tx_empty === 1'b1, "R5 frame length / tx_empty", tx_empty, 1);
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R1 txd idle high", txd, 1);
        chk(thr_empty === 1'b1, "R1 thr_empty", thr_empty, 1);
        chk(tx_empty === 1'b1, "R1 tx_empty", tx_empty, 1);
        chk(src_rd === 1'b0, "R1 no pop", src_rd, 0);

        // R2/R7: 8N1 back-to-back
        cfg_len = 2'd3; cfg_par_en = 0; cfg_stop2 = 0;
        send(8'h55);
        send(8'hA3);
        @(negedge clk);
        chk(thr_empty === 1'b0, "R7 second char held", thr_empty, 0);
        chk(tx_empty === 1'b0, "R8 not empty while holding", tx_empty, 0);
        wait_idle();

        // R3/R4: 5 bits, even parity; upper bits ignored
        cfg_len = 2'd0; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop2 = 0;
        send(8'hFF);
        send(8'h0A);
        wait_idle();

        // 6 bits, odd parity, 2 stop bits
        cfg_len = 2'd1; cfg_par_en = 1; cfg_par_odd = 1; cfg_stop2 = 1;
        send(8'h2C);
        send(8'h3F);
        wait_idle();

        // 7 bits, no parity, 2 stop bits
        cfg_len = 2'd2; cfg_par_en = 0; cfg_stop2 = 1;
        send(8'hFE);
        wait_idle();

        // 8 bits odd parity, all zeros
        cfg_len = 2'd3; cfg_par_en = 1; cfg_par_odd = 1; cfg_stop2 = 0;
        send(8'h00);
        wait_idle();

        // R6: settings changed mid-frame must not alter the frame
        cfg_len = 2'd3; cfg_par_en = 0; cfg_stop2 = 0;
        send(8'hC3);
        repeat (120) @(negedge clk);
        cfg_len = 2'd0; cfg_par_en = 1; cfg_stop2 = 1;
        wait_idle();
        cfg_len = 2'd3; cfg_par_en = 0; cfg_stop2 = 0;

        // R9: break from idle
        cfg_break = 1'b1;
        @(negedge clk);
        chk(txd === 1'b0, "R9 break low", txd, 0);
        repeat (20) @(negedge clk);
        chk(txd === 1'b0, "R9 break held", txd, 0);
        cfg_break = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R9 break released", txd, 1);

        // R10: freeze mid-frame
        hand(8'h00);
        repeat (60) @(negedge clk);
        chk(txd === 1'b0, "R10 frame running before freeze", txd, 0);
        freeze = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R10 line high on freeze", txd, 1);
        chk(tx_empty === 1'b1, "R10 sequencer idle", tx_empty, 1);
        src_data = 8'h81; src_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(src_rd === 1'b0, "R10 no pop frozen", src_rd, 0);
            chk(thr_empty === 1'b1, "R10 holding untouched", thr_empty, 1);
            chk(txd === 1'b1, "R10 line stays high", txd, 1);
        end
        begin
            exp_t e;
            e.d = 8'h81; e.len = cfg_len; e.pe = cfg_par_en; e.po = cfg_par_odd; e.s2 = cfg_stop2;
            exp_q.push_back(e);
        end
        freeze = 1'b0;
        hand(8'h81);
        wait_idle();

        finish_run();
    end
endmodule